// File: doc/BRIEF.md
# Disk Command List Interpreter

This block walks a linked list of commands held in a word-addressed memory on behalf of a disk controller. A one-cycle wake pulse makes it read a list pointer from a fixed control-block slot. A pointer of zero means there is no work. In that case the block clears the drive control register and goes back to sleep. Otherwise it fetches one command word at a time, plus an operand word when the command has one, and dispatches on a 4-bit code in the top bits of the command word.

Four commands are handled:
- Increment a memory word, and skip two words if the result wraps to zero.
- Jump within the current 256-word page.
- Send a control word to the drive, after pulsing a clear of the latched drive flags.
- Start an external transfer engine and wait for it. On success two words are skipped. On error the list falls through to the next word, which typically holds a jump to an error handler.

Any other code stops the interpreter in a trap state until the next wake.

Memory is reached through a single-outstanding request port. A read's data is used only in the cycle where the valid input is high. A write is complete when valid returns.

Top module: `dcl_interp`

## Requirements
- R1: After reset the block is idle (`idle_o`=1, `trap_o`=0, control word 0). A wake pulse while idle or trapped reads the word at control-block address `CB_ADDR` (default 4) and leaves the idle state on the next cycle.
- R2: A zero list pointer loads the control word with 0 without a preceding flag-clear pulse, and the block returns to idle without trapping.
- R3: A command word carries its code in bits [15:12]: 1 increment, 2 jump, 3 send, 4 transfer. Codes 1 to 3 have one operand word right after the command word, and by default execution continues at command address + 2.
- R4: Increment reads the word at the operand address, writes back the value plus one (modulo 2^16), and continues at command address + 4 when the written value is zero.
- R5: Jump replaces only the low 8 bits of the list pointer with the low 8 bits of the operand. The upper pointer bits are kept.
- R6: Send pulses `flag_clr_o` for one cycle and, in the next cycle, pulses `ctl_load_o` with `ctl_word_o` equal to the operand. `ctl_word_o` changes on no other occasion apart from R2.
- R7: Transfer reads no operand and pulses `xfer_start_o` once. When `xfer_done_i` arrives, a zero `xfer_status_i` continues at command address + 3 and a nonzero status continues at command address + 1.
- R8: Codes 0 and 5 to 15 raise `trap_o`. No further memory requests or control loads occur until a wake pulse restarts from the control block.
- R9: At most one memory request is outstanding. A new request is issued only after `mem_valid_i` has answered the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wake_i | input | 1 | One-cycle start pulse |
| idle_o | output | 1 | Dormant, waiting for wake |
| trap_o | output | 1 | Stopped on an unassigned command code |
| mem_req_o | output | 1 | One-cycle memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | AW | Word address |
| mem_wdata_o | output | DW | Write data |
| mem_rdata_i | input | DW | Read data, valid with mem_valid_i |
| mem_valid_i | input | 1 | Completion of the outstanding request |
| ctl_word_o | output | DW | Drive control register |
| ctl_load_o | output | 1 | Pulses when ctl_word_o is loaded |
| flag_clr_o | output | 1 | Clears latched drive flags |
| xfer_start_o | output | 1 | Starts the transfer engine |
| xfer_done_i | input | 1 | Transfer engine finished |
| xfer_status_i | input | ST_W | Transfer error bits, zero on success |

## Verification
A wrong list pointer does not stay hidden. Within a few commands it shows up as a different sequence of control-word loads, as increments landing on the wrong memory words, or as an early or late trap.

Skip-rule faults are the subtle ones, because they only matter when an increment result wraps or a transfer reports an error. For that reason the random lists place a two-word command right behind every increment and transfer, so each skip either suppresses or performs a visible control-word load.

Handshake faults appear at once. A request overlapping an outstanding one, or a load that is not preceded by a flag clear, is seen within one cycle at the ports.

// File: rtl/dcl_pkg.sv
package dcl_pkg;
   localparam int OPC_W = 4;

   localparam logic [OPC_W-1:0] OPC_INCSKIP = 4'd1;
   localparam logic [OPC_W-1:0] OPC_JUMP    = 4'd2;
   localparam logic [OPC_W-1:0] OPC_SEND    = 4'd3;
   localparam logic [OPC_W-1:0] OPC_XFER    = 4'd4;

   typedef struct packed {
      logic inc;
      logic jump;
      logic send;
      logic xfer;
      logic bad;
   } cmd_class_t;

   typedef enum logic [2:0] {
      PTR_HOLD,
      PTR_BASE,
      PTR_STEP,
      PTR_SKIP,
      PTR_JUMP
   } ptr_op_e;

   typedef enum logic [4:0] {
      S_IDLE,
      S_CB_REQ,
      S_CB_WT,
      S_CMD_REQ,
      S_CMD_WT,
      S_DECODE,
      S_OP_REQ,
      S_OP_WT,
      S_INC_RREQ,
      S_INC_RWT,
      S_INC_WREQ,
      S_INC_WWT,
      S_SEND_CLR,
      S_SEND_LD,
      S_XFER_GO,
      S_XFER_WT,
      S_TRAP
   } seq_state_e;
endpackage

// File: rtl/dcl_decode.sv
module dcl_decode
   import dcl_pkg::*;
(
   input  logic [OPC_W-1:0] opc_i,
   output cmd_class_t       cls_o
);
   localparam int NCODE = 2 ** OPC_W;

   logic [NCODE-1:0] hit;
   logic [NCODE-1:0] legal;

   for (genvar c = 0; c < NCODE; c++) begin : g_code
      assign hit[c]   = (opc_i == OPC_W'(c));
      assign legal[c] = (OPC_W'(c) == OPC_INCSKIP) || (OPC_W'(c) == OPC_JUMP) ||
                        (OPC_W'(c) == OPC_SEND)    || (OPC_W'(c) == OPC_XFER);
   end

   always_comb begin
      cls_o.inc  = hit[OPC_INCSKIP];
      cls_o.jump = hit[OPC_JUMP];
      cls_o.send = hit[OPC_SEND];
      cls_o.xfer = hit[OPC_XFER];
      cls_o.bad  = ~|(hit & legal);
   end
endmodule

// File: rtl/dcl_ptr.sv
module dcl_ptr
   import dcl_pkg::*;
#(
   parameter int AW        = 16,
   parameter int DW        = 16,
   parameter int PAGE_BITS = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  ptr_op_e       op_i,
   input  logic [DW-1:0] word_i,
   output logic [AW-1:0] ptr_o
);
   localparam logic [AW-1:0] ONE = AW'(1);
   localparam logic [AW-1:0] TWO = AW'(2);

   logic [AW-1:0] ptr_q;
   logic [AW-1:0] ptr_d;
   logic [AW-1:0] jump_val;

   if (AW > DW) begin : g_bad_width
      $error("dcl_ptr: AW must not exceed DW");
   end
   if (PAGE_BITS < 1) begin : g_bad_page
      $error("dcl_ptr: PAGE_BITS must be at least 1");
   end

   if (PAGE_BITS >= AW) begin : g_flat
      assign jump_val = word_i[AW-1:0];
   end else begin : g_paged
      assign jump_val = {ptr_q[AW-1:PAGE_BITS], word_i[PAGE_BITS-1:0]};
   end

   always_comb begin
      ptr_d = ptr_q;
      unique case (op_i)
         PTR_BASE: ptr_d = word_i[AW-1:0];
         PTR_STEP: ptr_d = ptr_q + ONE;
         PTR_SKIP: ptr_d = ptr_q + TWO;
         PTR_JUMP: ptr_d = jump_val;
         default:  ptr_d = ptr_q;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) ptr_q <= '0;
      else        ptr_q <= ptr_d;
   end

   assign ptr_o = ptr_q;
endmodule

// File: rtl/dcl_ctl_out.sv
module dcl_ctl_out #(
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr_req_i,
   input  logic          ld_req_i,
   input  logic [DW-1:0] ld_val_i,
   output logic [DW-1:0] ctl_word_o,
   output logic          ctl_load_o,
   output logic          flag_clr_o
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl_word_o <= '0;
         ctl_load_o <= 1'b0;
         flag_clr_o <= 1'b0;
      end else begin
         ctl_load_o <= ld_req_i;
         flag_clr_o <= clr_req_i;
         if (ld_req_i) ctl_word_o <= ld_val_i;
      end
   end
endmodule

// File: rtl/dcl_interp.sv
module dcl_interp
   import dcl_pkg::*;
#(
   parameter int AW           = 16,
   parameter int DW           = 16,
   parameter int ST_W         = 8,
   parameter int PAGE_BITS    = 8,
   parameter int unsigned CB_ADDR = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wake_i,
   output logic            idle_o,
   output logic            trap_o,
   output logic            mem_req_o,
   output logic            mem_we_o,
   output logic [AW-1:0]   mem_addr_o,
   output logic [DW-1:0]   mem_wdata_o,
   input  logic [DW-1:0]   mem_rdata_i,
   input  logic            mem_valid_i,
   output logic [DW-1:0]   ctl_word_o,
   output logic            ctl_load_o,
   output logic            flag_clr_o,
   output logic            xfer_start_o,
   input  logic            xfer_done_i,
   input  logic [ST_W-1:0] xfer_status_i
);
   localparam logic [AW-1:0] CB_A    = AW'(CB_ADDR);
   localparam int            OPC_LSB = DW - OPC_W;
   localparam logic [DW-1:0] INC_ONE = DW'(1);

   if (DW < OPC_W + 1) begin : g_bad_dw
      $error("dcl_interp: DW too narrow for the command field");
   end
   if (AW > DW) begin : g_bad_aw
      $error("dcl_interp: AW must not exceed DW");
   end
   if (ST_W < 1) begin : g_bad_st
      $error("dcl_interp: ST_W must be at least 1");
   end

   seq_state_e       state_q, state_d;
   logic [OPC_W-1:0] opc_q;
   logic [DW-1:0]    opnd_q;
   logic [DW-1:0]    data_q;
   logic             opc_ld, opnd_ld, data_ld;
   cmd_class_t       cls;
   ptr_op_e          pop;
   logic [AW-1:0]    ptr;
   logic             clr_req, ld_req;
   logic [DW-1:0]    ld_val;

   dcl_decode u_decode (
      .opc_i (opc_q),
      .cls_o (cls)
   );

   dcl_ptr #(
      .AW        (AW),
      .DW        (DW),
      .PAGE_BITS (PAGE_BITS)
   ) u_ptr (
      .clk    (clk),
      .rst_n  (rst_n),
      .op_i   (pop),
      .word_i (mem_rdata_i),
      .ptr_o  (ptr)
   );

   dcl_ctl_out #(
      .DW (DW)
   ) u_ctl (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr_req_i  (clr_req),
      .ld_req_i   (ld_req),
      .ld_val_i   (ld_val),
      .ctl_word_o (ctl_word_o),
      .ctl_load_o (ctl_load_o),
      .flag_clr_o (flag_clr_o)
   );

   always_comb begin
      state_d      = state_q;
      mem_req_o    = 1'b0;
      mem_we_o     = 1'b0;
      mem_addr_o   = ptr;
      mem_wdata_o  = data_q;
      pop          = PTR_HOLD;
      clr_req      = 1'b0;
      ld_req       = 1'b0;
      ld_val       = opnd_q;
      xfer_start_o = 1'b0;
      opc_ld       = 1'b0;
      opnd_ld      = 1'b0;
      data_ld      = 1'b0;
      unique case (state_q)
         S_IDLE: begin
            if (wake_i) state_d = S_CB_REQ;
         end
         S_CB_REQ: begin
            mem_req_o  = 1'b1;
            mem_addr_o = CB_A;
            state_d    = S_CB_WT;
         end
         S_CB_WT: begin
            if (mem_valid_i) begin
               if (mem_rdata_i == '0) begin
                  ld_req  = 1'b1;
                  ld_val  = '0;
                  state_d = S_IDLE;
               end else begin
                  pop     = PTR_BASE;
                  state_d = S_CMD_REQ;
               end
            end
         end
         S_CMD_REQ: begin
            mem_req_o = 1'b1;
            pop       = PTR_STEP;
            state_d   = S_CMD_WT;
         end
         S_CMD_WT: begin
            if (mem_valid_i) begin
               opc_ld  = 1'b1;
               state_d = S_DECODE;
            end
         end
         S_DECODE: begin
            if (cls.bad)       state_d = S_TRAP;
            else if (cls.xfer) state_d = S_XFER_GO;
            else               state_d = S_OP_REQ;
         end
         S_OP_REQ: begin
            mem_req_o = 1'b1;
            pop       = PTR_STEP;
            state_d   = S_OP_WT;
         end
         S_OP_WT: begin
            if (mem_valid_i) begin
               opnd_ld = 1'b1;
               if (cls.inc) begin
                  state_d = S_INC_RREQ;
               end else if (cls.jump) begin
                  pop     = PTR_JUMP;
                  state_d = S_CMD_REQ;
               end else begin
                  state_d = S_SEND_CLR;
               end
            end
         end
         S_INC_RREQ: begin
            mem_req_o  = 1'b1;
            mem_addr_o = opnd_q[AW-1:0];
            state_d    = S_INC_RWT;
         end
         S_INC_RWT: begin
            if (mem_valid_i) begin
               data_ld = 1'b1;
               state_d = S_INC_WREQ;
            end
         end
         S_INC_WREQ: begin
            mem_req_o  = 1'b1;
            mem_we_o   = 1'b1;
            mem_addr_o = opnd_q[AW-1:0];
            state_d    = S_INC_WWT;
         end
         S_INC_WWT: begin
            if (mem_valid_i) begin
               if (data_q == '0) pop = PTR_SKIP;
               state_d = S_CMD_REQ;
            end
         end
         S_SEND_CLR: begin
            clr_req = 1'b1;
            state_d = S_SEND_LD;
         end
         S_SEND_LD: begin
            ld_req  = 1'b1;
            state_d = S_CMD_REQ;
         end
         S_XFER_GO: begin
            xfer_start_o = 1'b1;
            state_d      = S_XFER_WT;
         end
         S_XFER_WT: begin
            if (xfer_done_i) begin
               if (xfer_status_i == '0) pop = PTR_SKIP;
               state_d = S_CMD_REQ;
            end
         end
         S_TRAP: begin
            if (wake_i) state_d = S_CB_REQ;
         end
         default: state_d = S_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         opc_q   <= '0;
         opnd_q  <= '0;
         data_q  <= '0;
      end else begin
         state_q <= state_d;
         if (opc_ld)  opc_q  <= mem_rdata_i[OPC_LSB +: OPC_W];
         if (opnd_ld) opnd_q <= mem_rdata_i;
         if (data_ld) data_q <= mem_rdata_i + INC_ONE;
      end
   end

   assign idle_o = (state_q == S_IDLE);
   assign trap_o = (state_q == S_TRAP);
endmodule

// File: rtl/dcl_interp_chk.sv
module dcl_interp_chk #(
   parameter int DW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          wake_i,
   input logic          idle_o,
   input logic          trap_o,
   input logic          mem_req_o,
   input logic          mem_valid_i,
   input logic [DW-1:0] ctl_word_o,
   input logic          ctl_load_o,
   input logic          flag_clr_o,
   input logic          xfer_start_o
);
   logic pend_q;

   always_ff @(posedge clk) begin
      if (!rst_n)           pend_q <= 1'b0;
      else if (mem_req_o)   pend_q <= 1'b1;
      else if (mem_valid_i) pend_q <= 1'b0;
   end

   AST_WAKE_LEAVES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      idle_o && wake_i |=> !idle_o); // R1
   AST_BARE_LOAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_load_o && !$past(flag_clr_o) |-> ctl_word_o == '0); // R2
   AST_CLR_THEN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      flag_clr_o |=> ctl_load_o); // R6
   AST_CTL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_load_o |-> $stable(ctl_word_o)); // R6
   AST_XFER_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_start_o |=> !xfer_start_o); // R7
   AST_TRAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      trap_o && !wake_i |=> trap_o); // R8
   AST_TRAP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      trap_o |-> !ctl_load_o && !flag_clr_o); // R8
   AST_SINGLE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q |-> !mem_req_o); // R9
endmodule

bind dcl_interp dcl_interp_chk #(.DW(DW)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .wake_i       (wake_i),
   .idle_o       (idle_o),
   .trap_o       (trap_o),
   .mem_req_o    (mem_req_o),
   .mem_valid_i  (mem_valid_i),
   .ctl_word_o   (ctl_word_o),
   .ctl_load_o   (ctl_load_o),
   .flag_clr_o   (flag_clr_o),
   .xfer_start_o (xfer_start_o)
);

// File: tb/dcl_interp_bench.sv
`timescale 1ns/1ps
module dcl_interp_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wake_i = 1'b0;
   logic        idle_o, trap_o;
   logic        mem_req_o, mem_we_o;
   logic [15:0] mem_addr_o, mem_wdata_o;
   logic [15:0] mem_rdata_i = '0;
   logic        mem_valid_i = 1'b0;
   logic [15:0] ctl_word_o;
   logic        ctl_load_o, flag_clr_o, xfer_start_o;
   logic        xfer_done_i = 1'b0;
   logic [7:0]  xfer_status_i = '0;

   always #2 clk = ~clk;

   dcl_interp u_dcl_interp (
      .clk(clk), .rst_n(rst_n), .wake_i(wake_i), .idle_o(idle_o), .trap_o(trap_o),
      .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
      .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i), .mem_valid_i(mem_valid_i),
      .ctl_word_o(ctl_word_o), .ctl_load_o(ctl_load_o), .flag_clr_o(flag_clr_o),
      .xfer_start_o(xfer_start_o), .xfer_done_i(xfer_done_i), .xfer_status_i(xfer_status_i)
   );

   int checks = 0;
   int errors = 0;

   logic [15:0] mem [0:255];
   logic [15:0] rm  [0:255];
   logic [7:0]  xs  [0:63];
   int          xi;

   logic        mbusy = 1'b0;
   int          mcnt = 0;
   logic [7:0]  maddr = '0;
   int          xcnt = -1;

   logic [15:0] act_log [0:63];
   int          act_n, act_clr, act_xfer, bad_req, overlap;
   logic [15:0] exp_log [0:63];
   int          exp_n, exp_clr, exp_xfer;
   logic        exp_trap;

   // memory model: single outstanding, 0..2 extra cycles of latency
   always @(negedge clk) begin
      if (mem_valid_i) mem_valid_i <= 1'b0;
      if (mem_req_o) begin
         if (mbusy) overlap <= overlap + 1;
         if (mem_we_o) mem[mem_addr_o[7:0]] <= mem_wdata_o;
         mbusy <= 1'b1;
         maddr <= mem_addr_o[7:0];
         mcnt  <= int'($urandom_range(0, 2));
      end else if (mbusy) begin
         if (mcnt == 0) begin
            mem_valid_i <= 1'b1;
            mem_rdata_i <= mem[maddr];
            mbusy <= 1'b0;
         end else begin
            mcnt <= mcnt - 1;
         end
      end
   end

   // transfer engine model and output monitors
   always @(negedge clk) begin
      if (xfer_done_i) xfer_done_i <= 1'b0;
      if (xfer_start_o) begin
         xcnt <= int'($urandom_range(1, 4));
         act_xfer <= act_xfer + 1;
      end else if (xcnt == 0) begin
         xfer_done_i   <= 1'b1;
         xfer_status_i <= xs[xi];
         xi   <= xi + 1;
         xcnt <= -1;
      end else if (xcnt > 0) begin
         xcnt <= xcnt - 1;
      end
      if (ctl_load_o) begin
         if (act_n < 64) act_log[act_n] <= ctl_word_o;
         act_n <= act_n + 1;
      end
      if (flag_clr_o) act_clr <= act_clr + 1;
      if (mem_req_o && (idle_o || trap_o)) bad_req <= bad_req + 1;
   end

   int cyc = 0;
   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         errors = errors + 1;
         $display("FAIL watchdog expired act=%0d exp=%0d", cyc, 150000);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks = checks + 1;
      if (!ok) begin
         errors = errors + 1;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   // reference interpreter over a copy of memory
   task automatic ref_run;
      logic [15:0] p, w, a;
      int k;
      int steps;
      k = 0; exp_n = 0; exp_clr = 0; exp_xfer = 0; exp_trap = 1'b0;
      for (int i = 0; i < 256; i++) rm[i] = mem[i];
      p = rm[4];
      if (p == 16'h0) begin
         exp_log[0] = 16'h0; exp_n = 1;
         return;
      end
      steps = 0;
      while (steps < 1000) begin
         steps++;
         w = rm[p[7:0]];
         p = p + 16'd1;
         case (w[15:12])
            4'd1: begin
               a = rm[p[7:0]]; p = p + 16'd1;
               rm[a[7:0]] = rm[a[7:0]] + 16'd1;
               if (rm[a[7:0]] == 16'h0) p = p + 16'd2;
            end
            4'd2: begin
               a = rm[p[7:0]];
               p = {p[15:8], a[7:0]};
            end
            4'd3: begin
               exp_log[exp_n] = rm[p[7:0]]; exp_n++; exp_clr++;
               p = p + 16'd1;
            end
            4'd4: begin
               exp_xfer++;
               if (xs[k] == 8'h0) p = p + 16'd2;
               k++;
            end
            default: begin
               exp_trap = 1'b1;
               return;
            end
         endcase
      end
   endtask

   task automatic run(input string tag);
      int t;
      ref_run();
      act_n = 0; act_clr = 0; act_xfer = 0; bad_req = 0; overlap = 0; xi = 0;
      @(negedge clk); wake_i = 1'b1;
      @(negedge clk); wake_i = 1'b0;
      @(negedge clk);
      t = 0;
      while (!(idle_o || trap_o) && t < 20000) begin
         @(negedge clk); t++;
      end
      repeat (3) @(negedge clk);
      chk(t < 20000, {tag, " finish R1"}, t, 20000);
      chk(trap_o == exp_trap, {tag, " trap state R8"}, 32'(trap_o), 32'(exp_trap));
      chk(idle_o == !exp_trap, {tag, " idle state R2"}, 32'(idle_o), 32'(!exp_trap));
      chk(act_n == exp_n, {tag, " control load count R6"}, act_n, exp_n);
      for (int i = 0; i < exp_n && i < act_n && i < 64; i++)
         chk(act_log[i] == exp_log[i], {tag, " control word sequence R3"}, act_log[i], exp_log[i]);
      chk(act_clr == exp_clr, {tag, " flag clear count R6"}, act_clr, exp_clr);
      chk(act_xfer == exp_xfer, {tag, " transfer starts R7"}, act_xfer, exp_xfer);
      for (int i = 8'h80; i < 8'h88; i++)
         chk(mem[i] == rm[i], {tag, " incremented words R4"}, mem[i], rm[i]);
      chk(overlap == 0, {tag, " single outstanding R9"}, overlap, 0);
      chk(bad_req == 0, {tag, " no request while stopped R8"}, bad_req, 0);
   endtask

   task automatic clear_mem;
      for (int i = 0; i < 256; i++) mem[i] = 16'h0;
      for (int i = 0; i < 64; i++) xs[i] = 8'h0;
   endtask

   task automatic gen_prog(input int n);
      logic [15:0] p;
      logic [15:0] c;
      int r, x;
      bit force_send;
      clear_mem();
      mem[4] = 16'h0020;
      p = 16'h0020; x = 0; force_send = 1'b0;
      for (int i = 8'h80; i < 8'h88; i++)
         mem[i] = ($urandom_range(0, 2) == 0) ? 16'hFFFF : 16'($urandom_range(0, 65535));
      for (int i = 0; i < n; i++) begin
         r = force_send ? 3 : int'($urandom_range(0, 3));
         force_send = 1'b0;
         case (r)
            0: begin
               mem[p[7:0]] = 16'h1000;
               mem[p[7:0] + 8'd1] = 16'h0080 + 16'($urandom_range(0, 7));
               p = p + 16'd2; force_send = 1'b1;
            end
            1: begin
               mem[p[7:0]] = 16'h2000;
               mem[p[7:0] + 8'd1] = {8'($urandom_range(0, 255)), 8'(p + 16'd2)};
               p = p + 16'd2;
            end
            2: begin
               mem[p[7:0]] = 16'h4000;
               xs[x] = ($urandom_range(0, 1) == 0) ? 8'h0 : 8'($urandom_range(1, 255));
               x++; p = p + 16'd1; force_send = 1'b1;
            end
            default: begin
               mem[p[7:0]] = 16'h3000;
               mem[p[7:0] + 8'd1] = 16'($urandom_range(1, 65535));
               p = p + 16'd2;
            end
         endcase
      end
      if (force_send) begin
         mem[p[7:0]] = 16'h3000; mem[p[7:0] + 8'd1] = 16'h5A5A; p = p + 16'd2;
      end
      c = 16'($urandom_range(5, 16));
      if (c == 16'd16) c = 16'd0;
      mem[p[7:0]] = {c[3:0], 12'h0};
   endtask

   initial begin
      void'($urandom(32'd20240611));
      clear_mem();
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk(idle_o == 1'b1, "reset idle R1", 32'(idle_o), 1);
      chk(trap_o == 1'b0, "reset no trap R1", 32'(trap_o), 0);
      chk(ctl_word_o == 16'h0, "reset control word R1", ctl_word_o, 0);
      chk(mem_req_o == 1'b0, "reset no request R1", 32'(mem_req_o), 0);

      // directed list: send, wrapping increment, jump with high bits, transfers
      mem[4]     = 16'h0020;
      mem[8'h20] = 16'h3000; mem[8'h21] = 16'hA5A5;
      mem[8'h22] = 16'h1000; mem[8'h23] = 16'h0080;
      mem[8'h24] = 16'h3000; mem[8'h25] = 16'h1111;
      mem[8'h26] = 16'h2000; mem[8'h27] = 16'hAB40;
      mem[8'h28] = 16'h3000; mem[8'h29] = 16'hDEAD;
      mem[8'h40] = 16'h1000; mem[8'h41] = 16'h0081;
      mem[8'h42] = 16'h3000; mem[8'h43] = 16'h2222;
      mem[8'h44] = 16'h4000;
      mem[8'h45] = 16'h3000; mem[8'h46] = 16'h3333;
      mem[8'h47] = 16'h4000;
      mem[8'h48] = 16'h3000; mem[8'h49] = 16'h4444;
      mem[8'h4A] = 16'hF000;
      mem[8'h80] = 16'hFFFF; mem[8'h81] = 16'h0005;
      xs[0] = 8'h00; xs[1] = 8'h07;
      run("directed");
      chk(ctl_word_o == 16'h4444, "transfer error falls through R7", ctl_word_o, 16'h4444);
      chk(mem[8'h80] == 16'h0000, "increment wraps to zero R4", mem[8'h80], 0);
      chk(mem[8'h81] == 16'h0006, "increment nonzero R4", mem[8'h81], 6);
      chk(act_n == 3 && act_log[0] == 16'hA5A5 && act_log[1] == 16'h2222,
          "jump keeps page R5", 32'(act_log[1]), 32'h2222);

      // nil pointer from the trapped state
      mem[4] = 16'h0000;
      run("nil");
      chk(ctl_word_o == 16'h0, "nil pointer clears control R2", ctl_word_o, 0);
      chk(act_clr == 0, "nil pointer no flag clear R2", act_clr, 0);

      // random lists
      for (int k = 0; k < 10; k++) begin
         gen_prog(int'($urandom_range(4, 18)));
         run("random");
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule